// File: doc/BRIEF.md
# Optical-Black Line Clamp

This block removes the dark offset from a raster of 14-bit sensor samples. Each line has a short run of masked (optical-black) columns before any pixel that is exposed to light. The block averages a programmable window of 8 or 16 of those columns. It then folds that average into a running black reference with a first-order recursive filter. The filter weight is a power of two, so no multiplier is needed. Every later sample on the same line has the reference subtracted from it and leaves with an active flag.

Samples enter and leave on valid/ready streams. An input sample is accepted on a rising edge where `s_valid` and `s_ready` are both high. An output sample is consumed on a rising edge where `m_valid` and `m_ready` are both high. There is a single output register, so `s_ready` stays high while the output slot is empty or is being drained in the same cycle. Back-pressure on `m_ready` therefore reaches the input with no extra delay. The line-start and frame-start strobes travel with the sample they mark. Configuration inputs must stay constant for the whole of a line.

Top module: `ob_black_clamp`

## Requirements
- R1: After reset, `m_valid` is 0 and `s_ready` is 1.
- R2: An accepted sample with `s_sol`=1 is column 0 of its line. Each further accepted sample on that line is one column higher.
- R3: The black window covers columns `cfg_win_start` through `cfg_win_start`+N−1, where N is 16 when `cfg_win16`=1 and 8 when it is 0. The window average is the floor of the window sum divided by N.
- R4: On the first line to complete its window after an accepted sample with `s_sof`=1, the reference is loaded with the window average directly. A frame-start sample must also carry `s_sol`=1.
- R5: On every other line, the reference becomes ref + ((avg − ref) >>> `cfg_shift`). The shift is arithmetic, so it rounds toward minus infinity. With `cfg_shift`=0 the reference equals the average.
- R6: A sample in any column up to and including the last window column leaves unchanged, with `m_active`=0.
- R7: A sample after the last window column of its line leaves as max(sample − ref, 0), with `m_active`=1. The value of ref used here is the one updated on that line.
- R8: While `m_valid`=1 and `m_ready`=0, `m_valid`, `m_data` and `m_active` hold their values.
- R9: `s_ready` equals `m_ready` OR NOT `m_valid`. An accepted sample is presented at the output in the following cycle.
- R10: Every accepted sample produces exactly one output sample, in order of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shift | input | 3 | Filter weight as a right-shift amount (0..7) |
| cfg_win_start | input | 12 | First column of the black window |
| cfg_win16 | input | 1 | 1: 16-column window, 0: 8-column window |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_data | input | 14 | Input sample |
| s_sol | input | 1 | Sample is the first of a line |
| s_sof | input | 1 | Sample is the first of a frame |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream accepts the output sample |
| m_data | output | 14 | Output sample, corrected or passed through |
| m_active | output | 1 | 1 when m_data has been corrected |

## Verification
The hardest case to reach from the ports is a filter update with a negative difference and a large shift, where the floor rounding of the arithmetic shift is the only thing that shows. A close second is a corrected sample that falls below the reference and has to clamp at zero. The stimulus varies the black level from line to line around a drifting base, sometimes above and sometimes below the current reference. It also draws some exposed samples from below the black level. Window position, window length and shift are drawn again for every frame, and random gaps and stalls are laid over the stream.

// File: rtl/ob_clamp_pkg.sv
package ob_clamp_pkg;
  typedef enum logic {WIN_8 = 1'b0, WIN_16 = 1'b1} win_len_e;
  localparam int LOG_WIN8  = 3;
  localparam int LOG_WIN16 = 4;
endpackage

// File: rtl/ob_col_track.sv
module ob_col_track #(
  parameter int COL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             sol,
  input  logic [COL_W-1:0] win_start,
  input  logic             win16,
  output logic             in_win,
  output logic             win_first,
  output logic             win_last,
  output logic             past_win
);
  import ob_clamp_pkg::*;
  localparam logic [COL_W-1:0] COL_MAX = '1;

  logic [COL_W-1:0] col_q, col_eff;
  logic [COL_W:0]   win_end;
  logic             done_q;

  assign col_eff   = sol ? '0 : col_q;
  assign win_end   = {1'b0, win_start} + ((win_len_e'(win16) == WIN_16) ? (COL_W+1)'(15) : (COL_W+1)'(7));
  assign in_win    = ({1'b0, col_eff} >= {1'b0, win_start}) && ({1'b0, col_eff} <= win_end);
  assign win_first = (col_eff == win_start);
  assign win_last  = ({1'b0, col_eff} == win_end);
  assign past_win  = done_q && !sol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q  <= '0;
      done_q <= 1'b0;
    end else if (acc) begin
      col_q  <= (col_eff == COL_MAX) ? COL_MAX : col_eff + 1'b1;
      done_q <= win_last ? 1'b1 : (sol ? 1'b0 : done_q);
    end
  end

  // R6
  last_not_past_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && win_last) |-> !past_win);
endmodule

// File: rtl/ob_black_level.sv
module ob_black_level #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [DATA_W-1:0] pix,
  input  logic              sof,
  input  logic              in_win,
  input  logic              win_first,
  input  logic              win_last,
  input  logic              win16,
  input  logic [2:0]        shift,
  output logic [DATA_W-1:0] ref_lvl
);
  import ob_clamp_pkg::*;
  localparam int SUM_W = DATA_W + LOG_WIN16;

  logic [SUM_W-1:0]        sum_q, sum_nxt;
  logic [DATA_W-1:0]       avg, blended;
  logic signed [DATA_W:0]  diff, step;
  logic                    first_q, first_eff;

  assign first_eff = first_q || sof;
  assign sum_nxt   = (win_first ? '0 : sum_q) + SUM_W'(pix);
  assign avg       = win16 ? DATA_W'(sum_nxt >> LOG_WIN16) : DATA_W'(sum_nxt >> LOG_WIN8);
  assign diff      = $signed({1'b0, avg}) - $signed({1'b0, ref_lvl});
  assign step      = diff >>> shift;
  assign blended   = ref_lvl + step[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q   <= '0;
      first_q <= 1'b0;
      ref_lvl <= '0;
    end else if (acc) begin
      if (in_win) sum_q <= sum_nxt;
      if (win_last) begin
        ref_lvl <= first_eff ? avg : blended;
        first_q <= 1'b0;
      end else if (sof) begin
        first_q <= 1'b1;
      end
    end
  end

  // R5
  blend_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && win_last && !first_eff) |=>
      ((ref_lvl >= $past(ref_lvl) && ref_lvl <= $past(avg)) ||
       (ref_lvl <= $past(ref_lvl) && ref_lvl >= $past(avg))));

  // R4
  first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && win_last && first_eff) |=> ref_lvl == $past(avg));
endmodule

// File: rtl/ob_out_stage.sv
module ob_out_stage #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] pix,
  input  logic              past_win,
  input  logic [DATA_W-1:0] ref_lvl,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_active
);
  logic [DATA_W-1:0] corr;

  assign s_ready = m_ready || !m_valid;
  assign corr    = (pix > ref_lvl) ? pix - ref_lvl : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_data   <= '0;
      m_active <= 1'b0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) begin
        m_data   <= past_win ? corr : pix;
        m_active <= past_win;
      end
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_active)));

  // R7
  corr_le_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && past_win) |=> (m_active && m_data <= $past(pix)));

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid);
endmodule

// File: rtl/ob_black_clamp.sv
module ob_black_clamp #(
  parameter int DATA_W = 14,
  parameter int COL_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_shift,
  input  logic [COL_W-1:0]  cfg_win_start,
  input  logic              cfg_win16,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_sol,
  input  logic              s_sof,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_active
);
  logic acc, in_win, win_first, win_last, past_win;
  logic [DATA_W-1:0] ref_lvl;

  assign acc = s_valid && s_ready;

  ob_col_track #(.COL_W(COL_W)) u_col (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sol(s_sol),
    .win_start(cfg_win_start), .win16(cfg_win16),
    .in_win(in_win), .win_first(win_first), .win_last(win_last), .past_win(past_win)
  );

  ob_black_level #(.DATA_W(DATA_W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .acc(acc), .pix(s_data), .sof(s_sof),
    .in_win(in_win), .win_first(win_first), .win_last(win_last),
    .win16(cfg_win16), .shift(cfg_shift), .ref_lvl(ref_lvl)
  );

  ob_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .pix(s_data), .past_win(past_win), .ref_lvl(ref_lvl),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_active(m_active)
  );

  // R10
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_valid && !s_valid) |=> !m_valid);
endmodule

// File: tb/ob_black_clamp_tb.sv
module ob_black_clamp_tb;
  localparam int PERIOD   = 10;
  localparam int LINE_LEN = 40;
  localparam int NLINES   = 8;
  localparam int NFRAMES  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_shift = '0;
  logic [11:0] cfg_win_start = '0;
  logic cfg_win16 = 1'b0;
  logic s_valid = 1'b0, s_sol = 1'b0, s_sof = 1'b0, m_ready = 1'b0;
  logic [13:0] s_data = '0;
  logic s_ready, m_valid, m_active;
  logic [13:0] m_data;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [14:0] expq[$];
  int mcol = 0, macc = 0, mref = 0;
  bit mfirst = 0, mdone = 0;
  bit prev_stall = 0;
  logic [13:0] prev_data;
  logic prev_act;

  ob_black_clamp u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_win_start(cfg_win_start),
    .cfg_win16(cfg_win16), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sol(s_sol), .s_sof(s_sof), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_active(m_active)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model, from R2..R7
  function automatic logic [14:0] model(input int d, input bit sol, input bit sof);
    int col, endc, nwin, sum, avg, step;
    bit past, first;
    logic [14:0] r;
    col   = sol ? 0 : mcol;
    nwin  = cfg_win16 ? 16 : 8;
    endc  = cfg_win_start + nwin - 1;
    past  = mdone && !sol;
    first = mfirst || sof;
    if (sol) mdone = 0;
    if (past) r = {1'b1, 14'((d > mref) ? d - mref : 0)};
    else      r = {1'b0, 14'(d)};
    sum = (col == cfg_win_start) ? d : macc + d;
    if (col >= cfg_win_start && col <= endc) macc = sum;
    mfirst = first;
    if (col == endc) begin
      avg = sum / nwin;
      if (first) mref = avg;
      else begin
        step = (avg - mref) >>> cfg_shift;
        mref = mref + step;
      end
      mdone  = 1;
      mfirst = 0;
    end
    mcol = col + 1;
    return r;
  endfunction

  task automatic observe();
    logic [14:0] e;
    check(s_ready == (m_ready || !m_valid), "R9 s_ready", s_ready, m_ready || !m_valid);
    if (prev_stall)
      check(m_valid && m_data == prev_data && m_active == prev_act, "R8 stall hold",
            m_data, prev_data);
    if (m_valid && m_ready) begin
      if (expq.size() == 0) check(0, "R10 extra output", m_data, -1);
      else begin
        e = expq.pop_front();
        if (e[14])
          check(m_active && m_data == e[13:0], "R7 corrected (ref per R2/R3/R4/R5)",
                {m_active, m_data}, e);
        else
          check(!m_active && m_data == e[13:0], "R6 pass-through (window per R3)",
                {m_active, m_data}, e);
      end
    end
    if (s_valid && s_ready) expq.push_back(model(s_data, s_sol, s_sof));
    prev_stall = m_valid && !m_ready;
    prev_data  = m_data;
    prev_act   = m_active;
  endtask

  task automatic send(input int d, input bit sol, input bit sof, input bit tight);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      m_ready = tight ? 1'b1 : ($urandom_range(0, 3) != 0);
      if (!tight && $urandom_range(0, 4) == 0) s_valid = 1'b0;
      else begin
        s_valid = 1'b1; s_data = 14'(d); s_sol = sol; s_sof = sof;
      end
      #1;
      done = s_valid && s_ready;
      observe();
    end
    @(negedge clk);
    s_valid = 1'b0;
    m_ready = 1'b1;
    #1;
    observe();
  endtask

  initial begin
    int base, blk, px;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check(m_valid == 1'b0 && s_ready == 1'b1, "R1 reset state", {m_valid, s_ready}, 1);
    rst_n = 1'b1;
    base = 900;
    for (int f = 0; f < NFRAMES; f++) begin
      if (f == 0) begin cfg_shift = 3'd0; cfg_win16 = 1'b0; cfg_win_start = 12'd2; end
      else if (f == 1) begin cfg_shift = 3'd7; cfg_win16 = 1'b1; cfg_win_start = 12'd0; end
      else begin
        cfg_shift = 3'($urandom_range(0, 7));
        cfg_win16 = 1'($urandom_range(0, 1));
        cfg_win_start = 12'($urandom_range(0, 10));
      end
      for (int l = 0; l < NLINES; l++) begin
        base = base + $urandom_range(0, 300) - 150;
        if (base < 200) base = 200;
        for (int c = 0; c < LINE_LEN; c++) begin
          blk = base + $urandom_range(0, 60) - 30;
          if (c < 26) px = blk;
          else if ($urandom_range(0, 3) == 0) px = base - $urandom_range(1, 150);
          else px = $urandom_range(0, 16383);
          send(px, c == 0, (c == 0) && (l == 0), f == 0);
        end
      end
    end
    repeat (4) begin
      @(negedge clk); m_ready = 1'b1; s_valid = 1'b0; #1; observe();
    end
    check(expq.size() == 0, "R10 all outputs delivered", expq.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule